// File: doc/BRIEF.md
# Memory-Mapped Character Input and Output Port

This peripheral sits on a simple single-cycle processor bus and gives software a way to receive ASCII characters from an external producer and to send characters to an external consumer. An incoming character arrives as an 8-bit code with a one-cycle valid strobe. The port latches it, raises a "character received" flag, and can signal an interrupt to the processor. Software polls or services the interrupt, then reads the character back over the bus.

Three byte offsets are decoded. Offset 0 is a control/status byte. Bit 7 of this byte is a read/write interrupt enable. Bit 6 is the received flag. Offset 1 returns the last received character. Offset 2 is a write-only transmit register. Any write to offset 2 is forwarded to the consumer as a one-cycle strobe that carries the byte. Reads are combinational in the cycle the access is presented. Register updates take effect at the clock edge that ends the access.

Top module: `char_io_port`

## Requirements
- R1: After reset, the control/status byte reads 0x00, the character byte reads 0x00, `irq` is 0 and `txValid` is 0.
- R2: A cycle with `rxValid` high stores `rxChar`. From the next cycle, offset 1 reads that code and bit 6 of offset 0 reads 1.
- R3: A new character overwrites the stored one even when the previous character was never read.
- R4: A read of offset 1 returns the stored code in the same cycle and clears the received flag from the next cycle.
- R5: A write to offset 0 loads bit 7 of the write data into the enable. It clears the flag when write-data bit 6 is 0, and leaves the flag unchanged when that bit is 1.
- R6: If a character arrives in the same cycle as a clearing read or a clearing write, the flag ends up set and the new code is stored.
- R7: `irq` is 1 exactly while the enable bit and the received flag are both 1.
- R8: Bits 5 to 0 of offset 0 always read 0. Writes to offset 1 and offset 3 change nothing.
- R9: A write to offset 2 makes `txValid` 1 for the following cycle only, with `txChar` equal to the written byte. Writes to any other offset never raise `txValid`.
- R10: `busRdata` is 0x00 when no read is presented, and when offset 2 or 3 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access presented this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Byte offset within the port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the access cycle |
| rxValid | input | 1 | Incoming character strobe |
| rxChar | input | 8 | Incoming character code |
| irq | output | 1 | Interrupt request, level |
| txValid | output | 1 | Outgoing character strobe |
| txChar | output | 8 | Outgoing character code |

## Verification
The assertions check the following on every cycle:
- the interrupt level agrees with the two status bits whenever the status byte is read;
- the low six status bits read 0;
- a just-arrived character is visible as both the flag and the code;
- a data read without a coincident arrival clears the flag;
- every transmit strobe traces back to a write at offset 2 and carries that write's byte.

Other properties can only be shown by the bench scenarios:
- overwrite of an unread character;
- the same-cycle race between an arrival and a clear;
- the write-1-keeps-flag rule;
- ignored writes to the character and spare offsets;
- full sweeps of all 256 codes in both directions.

// File: rtl/char_io_port_pkg.sv
package char_io_port_pkg;
  localparam int CTRL_OFF   = 0;
  localparam int DATA_OFF   = 1;
  localparam int TX_OFF     = 2;
  localparam int ENABLE_BIT = 7;
  localparam int FLAG_BIT   = 6;

  typedef struct packed {
    logic loadChar;   // capture incoming code, set flag
    logic clrFlag;    // clear request from read or write
    logic wrEnable;   // load enable bit from write data
    logic wrTx;       // launch transmit strobe
    logic rdCtrl;     // drive status byte on read bus
    logic rdData;     // drive character byte on read bus
  } portCtl_t;
endpackage

// File: rtl/char_io_port_ctrl.sv
module char_io_port_ctrl
  import char_io_port_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              rxValid,
  output portCtl_t          ctl
);
  logic hitCtrl, hitData, hitTx;

  always_comb begin
    hitCtrl = busSel && (busAddr == ADDR_W'(CTRL_OFF));
    hitData = busSel && (busAddr == ADDR_W'(DATA_OFF));
    hitTx   = busSel && (busAddr == ADDR_W'(TX_OFF));

    ctl.loadChar = rxValid;
    ctl.rdCtrl   = hitCtrl && !busWrite;
    ctl.rdData   = hitData && !busWrite;
    ctl.wrEnable = hitCtrl && busWrite;
    ctl.wrTx     = hitTx && busWrite;
    ctl.clrFlag  = ctl.rdData || (ctl.wrEnable && !busWdata[FLAG_BIT]);
  end
endmodule

// File: rtl/char_io_port_dp.sv
module char_io_port_dp
  import char_io_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portCtl_t          ctl,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] rxChar,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq,
  output logic              txValid,
  output logic [DATA_W-1:0] txChar
);
  logic              enableQ;
  logic              flagQ;
  logic [DATA_W-1:0] charQ;
  logic              txValidQ;
  logic [DATA_W-1:0] txCharQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      flagQ    <= 1'b0;
      charQ    <= '0;
      txValidQ <= 1'b0;
      txCharQ  <= '0;
    end else begin
      if (ctl.wrEnable) enableQ <= busWdata[ENABLE_BIT];
      if (ctl.loadChar) begin
        flagQ <= 1'b1;
        charQ <= rxChar;
      end else if (ctl.clrFlag) begin
        flagQ <= 1'b0;
      end
      txValidQ <= ctl.wrTx;
      if (ctl.wrTx) txCharQ <= busWdata;
    end
  end

  always_comb begin
    busRdata = '0;
    if (ctl.rdCtrl) begin
      busRdata[ENABLE_BIT] = enableQ;
      busRdata[FLAG_BIT]   = flagQ;
    end else if (ctl.rdData) begin
      busRdata = charQ;
    end
  end

  assign irq     = enableQ && flagQ;
  assign txValid = txValidQ;
  assign txChar  = txCharQ;
endmodule

// File: rtl/char_io_port.sv
module char_io_port
  import char_io_port_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxChar,
  output logic              irq,
  output logic              txValid,
  output logic [DATA_W-1:0] txChar
);
  portCtl_t ctl;

  char_io_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .rxValid(rxValid), .ctl(ctl)
  );

  char_io_port_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busWdata(busWdata),
    .rxChar(rxChar), .busRdata(busRdata), .irq(irq),
    .txValid(txValid), .txChar(txChar)
  );
endmodule

// File: rtl/char_io_port_chk.sv
module char_io_port_chk
  import char_io_port_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxChar,
  input logic              irq,
  input logic              txValid,
  input logic [DATA_W-1:0] txChar
);
  logic seeCtrl, seeData, putTx;
  assign seeCtrl = busSel && !busWrite && (busAddr == ADDR_W'(CTRL_OFF));
  assign seeData = busSel && !busWrite && (busAddr == ADDR_W'(DATA_OFF));
  assign putTx   = busSel && busWrite && (busAddr == ADDR_W'(TX_OFF));

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    seeCtrl |-> (irq == (busRdata[ENABLE_BIT] && busRdata[FLAG_BIT])));

  // R8
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    seeCtrl |-> (busRdata[5:0] == 6'd0));

  // R2
  arrive_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxValid) && seeCtrl) |-> busRdata[FLAG_BIT]);

  // R2
  arrive_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxValid) && seeData) |-> (busRdata == $past(rxChar)));

  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(seeData && !rxValid) && seeCtrl) |-> !busRdata[FLAG_BIT]);

  // R9
  tx_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(putTx));

  // R9
  tx_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txChar == $past(busWdata)));
endmodule

bind char_io_port char_io_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .rxValid(rxValid), .rxChar(rxChar), .irq(irq),
  .txValid(txValid), .txChar(txChar)
);

// File: tb/char_io_port_test.sv
`timescale 1ns/1ps
module char_io_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWrite = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0, busRdata;
  logic       rxValid = 1'b0;
  logic [7:0] rxChar = 8'd0;
  logic       irq, txValid;
  logic [7:0] txChar;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  char_io_port uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rxValid(rxValid), .rxChar(rxChar), .irq(irq),
    .txValid(txValid), .txChar(txChar)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] v);
    busSel = 1; busWrite = 0; busAddr = a; #1;
    v = busRdata;
    tick();
    busSel = 0;
  endtask

  task automatic busWriteOp(input logic [1:0] a, input logic [7:0] d);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    tick();
    busSel = 0; busWrite = 0;
  endtask

  task automatic push(input logic [7:0] c);
    rxValid = 1; rxChar = c;
    tick();
    rxValid = 0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       en;
    repeat (3) tick();
    rstN = 1;
    #1;
    check("R10 idle rdata", busRdata, 0);
    check("R1 irq", irq, 0);
    check("R1 txValid", txValid, 0);
    busRead(0, v); check("R1 ctrl", v, 0);
    busRead(1, v); check("R1 data", v, 0);

    // Receive sweep over every code, enable alternating (R2 R3 R4 R7 R8)
    for (int c = 0; c < 256; c++) begin
      en = c[0];
      busWriteOp(0, {en, 7'd0});
      if (c % 4 == 0) push(8'(c) ^ 8'h5A);
      push(8'(c));
      check("R7 irq set", irq, en);
      busRead(0, v); check("R2 R8 ctrl after arrival", v, {en, 1'b1, 6'd0});
      busRead(1, v); check("R2 R3 data", v, c);
      busRead(0, v); check("R4 flag cleared", v, {en, 7'd0});
      check("R7 irq clear", irq, 0);
    end

    // Write 1 to flag bit keeps it; write 0 clears (R5)
    push(8'h41);
    busWriteOp(0, 8'hC0);
    check("R7 irq enabled", irq, 1);
    busRead(0, v); check("R5 write1 keeps", v, 8'hC0);
    busWriteOp(0, 8'h80);
    busRead(0, v); check("R5 write0 clears", v, 8'h80);
    check("R7 irq after clear", irq, 0);
    busWriteOp(0, 8'h7F);
    busRead(0, v); check("R5 enable off", v, 8'h00);

    // Ignored writes (R8)
    busWriteOp(1, 8'hAA);
    busWriteOp(3, 8'h55);
    check("R9 no tx from other offsets", txValid, 0);
    busRead(1, v); check("R8 data write ignored", v, 8'h41);
    busRead(0, v); check("R8 ctrl unchanged", v, 8'h00);
    busRead(2, v); check("R10 offset2 reads 0", v, 0);
    busRead(3, v); check("R10 offset3 reads 0", v, 0);

    // Race: arrival with data read (R6)
    busSel = 1; busWrite = 0; busAddr = 1; rxValid = 1; rxChar = 8'h62; #1;
    check("R6 read returns old", busRdata, 8'h41);
    tick(); busSel = 0; rxValid = 0;
    busRead(0, v); check("R6 flag after read race", v, 8'h40);
    busRead(1, v); check("R6 code after read race", v, 8'h62);
    // Race: arrival with clearing write
    busSel = 1; busWrite = 1; busAddr = 0; busWdata = 8'h80; rxValid = 1; rxChar = 8'h63;
    tick(); busSel = 0; busWrite = 0; rxValid = 0;
    check("R6 R7 irq after write race", irq, 1);
    busRead(0, v); check("R6 flag after write race", v, 8'hC0);
    busRead(1, v); check("R6 code after write race", v, 8'h63);

    // Transmit sweep (R9)
    for (int d = 0; d < 256; d++) begin
      busWriteOp(2, 8'(d));
      check("R9 txValid", txValid, 1);
      check("R9 txChar", txChar, d);
      tick();
      check("R9 strobe one cycle", txValid, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule